// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by way of a 7-bit down-counter that a free-running prescaler advances at a selectable rate. Software must refresh the counter before bit 6 of the counter drops. If it refreshes too early, while the counter is still above a programmed window value, that is also treated as a fault. Either fault raises a one-cycle system reset request, but only after the watchdog has been armed. The arm bit cannot be cleared by a register write once set.

Software may also enable an early warning. The early warning raises a sticky interrupt at the moment the counter reaches the value just above the fault threshold. That gives software a last chance to refresh. Three registers sit on a simple single-cycle write and combinational read bus:

- address 0: control, holding the arm bit and the counter value.
- address 1: configuration, holding the window value, the early-warning enable and the timebase.
- address 2: status, holding the warning flag.

Top module: `wwd_window_watchdog`

## Requirements
- R1: The counter decrements by one once every 2^(BASE_LOG2+TB) clock cycles, where TB is configuration bits 13:11. The prescaler runs freely from reset and ticks on its last cycle of each period. The counter wraps from 0x00 to 0x7F, and it keeps running while the watchdog is not armed.
- R2: After reset, control (address 0) reads 0x7F with the arm bit at 0, configuration (address 1) reads 0x7F, status (address 2) reads 0, and both outputs are low.
- R3: While armed, `rst_req` is high for exactly the one cycle after the clock edge at which the counter steps from 0x40 to 0x3F. While not armed, no reset request is ever raised.
- R4: Writing 1 to control bit 7 arms the watchdog. Writing 0 to it leaves the watchdog armed; only reset disarms it.
- R5: A control write loads bits 6:0 into the counter, and a prescaler tick in that same cycle is dropped. If the watchdog is armed and the counter is above the window value (configuration bits 6:0), the write instead raises `rst_req` in the next cycle and leaves the counter unchanged. While not armed, the counter is always loaded.
- R6: Configuration bit 9 enables the early warning. Writing 1 sets it and writing 0 has no effect. While it is set, a tick that steps the counter from 0x41 to 0x40 sets the warning flag, and `irq_early` follows the flag.
- R7: The warning flag reads at status bit 0. Writing 0 there clears it and writing 1 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R8: Register bits outside the defined fields read as zero and ignore writes. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request |
| irq_early | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with BASE_LOG2 = 2, so a prescaler period is 4 to 512 cycles instead of 4096 to 524288. This makes every timebase setting reachable, and each one runs for many ticks. At TB = 0, the counter completes several full wraps within a few thousand cycles, crossing 0x40 both armed and unarmed. Because of that, a cycle-accurate arithmetic model can compare the counter, the reset pulse and the interrupt on every cycle, with window refreshes placed on both sides of the window value.

// File: rtl/wwd_pkg.sv
// Shared register addresses and fixed field positions of the windowed watchdog.
// Assumes the counter is at most 9 bits wide so the fixed fields do not overlap.
package wwd_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam int         EWE_BIT   = 9;
    localparam int         TB_LSB    = 11;
    localparam int         FLAG_BIT  = 0;
endpackage

// File: rtl/wwd_prescaler.sv
// Free-running prescaler: emits a one-cycle tick every 2^(BASE_LOG2+tb) cycles.
// Assumes tb may change at any time; the period of the next tick follows it.
module wwd_prescaler #(
    parameter int BASE_LOG2 = 12,
    parameter int TB_W      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] tb,
    output logic            tick
);
    localparam int PW = BASE_LOG2 + (1 << TB_W) - 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] mask;

    // Select the low bits that must all be one for a tick.
    always_comb begin
        mask = {PW{1'b1}} >> (~tb);
        tick = &(pcnt | ~mask);
    end

    // Advance the free-running count.
    always_ff @(posedge clk) begin
        if (!rst_n) pcnt <= '0;
        else        pcnt <= pcnt + 1'b1;
    end

    generate
        if (BASE_LOG2 >= 1) begin : g_chk
            assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/wwd_counter.sv
// Down-counter with window check and fault detection.
// Assumes load is a control write; load wins over a tick in the same cycle.
module wwd_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             active,
    input  logic [CNT_W-1:0] window,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req,
    output logic             hit_mid
);
    localparam logic [CNT_W-1:0] MID    = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] MID_P1 = MID + 1'b1;

    logic early_load;
    logic take_load;
    logic step;

    // Classify this cycle's write and tick.
    always_comb begin
        early_load = load & active & (cnt > window);
        take_load  = load & ~early_load;
        step       = tick & ~load;
        hit_mid    = step & (cnt == MID_P1);
    end

    // Hold, load or decrement the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '1;
        else if (take_load) cnt <= load_val;
        else if (step)      cnt <= cnt - 1'b1;
    end

    // Register a one-cycle fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= early_load | (active & step & (cnt == MID));
    end

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (cnt == $past(cnt) - 1'b1));
    assert_early_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && active && cnt > window) |=> (rst_req && cnt == $past(cnt)));
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> !rst_req);
endmodule

// File: rtl/wwd_regs.sv
// Register file: sticky arm and enable bits, window, timebase, warning flag, read mux.
// Assumes a single-cycle write strobe and a combinational read.
module wwd_regs
    import wwd_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int TB_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             hit_mid,
    output logic             active,
    output logic             ewe,
    output logic [CNT_W-1:0] window,
    output logic [TB_W-1:0]  tb,
    output logic             flag,
    output logic             ctrl_load,
    output logic [31:0]      bus_rdata
);
    logic cfg_wr;
    logic stat_wr;

    // Decode the write target.
    always_comb begin
        ctrl_load = bus_wr & (bus_addr == ADDR_CTRL);
        cfg_wr    = bus_wr & (bus_addr == ADDR_CFG);
        stat_wr   = bus_wr & (bus_addr == ADDR_STAT);
    end

    // Arm bit: set by write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         active <= 1'b0;
        else if (ctrl_load && bus_wdata[CNT_W]) active <= 1'b1;
    end

    // Configuration fields; the enable bit only sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window <= '1;
            tb     <= '0;
            ewe    <= 1'b0;
        end else if (cfg_wr) begin
            window <= bus_wdata[CNT_W-1:0];
            tb     <= bus_wdata[TB_LSB +: TB_W];
            ewe    <= ewe | bus_wdata[EWE_BIT];
        end
    end

    // Sticky warning flag: set wins over a write-0 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                flag <= 1'b0;
        else if (hit_mid && ewe)                   flag <= 1'b1;
        else if (stat_wr && !bus_wdata[FLAG_BIT])  flag <= 1'b0;
    end

    // Combinational read mux with zeroed unused bits.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CNT_W-1:0] = cnt;
                bus_rdata[CNT_W]     = active;
            end
            ADDR_CFG: begin
                bus_rdata[CNT_W-1:0]        = window;
                bus_rdata[EWE_BIT]          = ewe;
                bus_rdata[TB_LSB +: TB_W]   = tb;
            end
            ADDR_STAT: bus_rdata[FLAG_BIT] = flag;
            default:   bus_rdata = '0;
        endcase
    end

    assert_arm_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> active);
    assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ewe |=> ewe);
    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(hit_mid && ewe)) |=> !flag);
    assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_wr) |=> flag);
endmodule

// File: rtl/wwd_window_watchdog.sv
// Windowed watchdog top: prescaler, counter and registers wired together.
// Assumes rst_req is consumed by an external reset controller.
module wwd_window_watchdog #(
    parameter int BASE_LOG2 = 12,
    parameter int CNT_W     = 7,
    parameter int TB_W      = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req,
    output logic        irq_early
);
    logic             tick;
    logic             hit_mid;
    logic             active;
    logic             ewe;
    logic             flag;
    logic             ctrl_load;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] window;
    logic [TB_W-1:0]  tb;

    wwd_prescaler #(.BASE_LOG2(BASE_LOG2), .TB_W(TB_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .tb(tb), .tick(tick)
    );

    wwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(ctrl_load),
        .load_val(bus_wdata[CNT_W-1:0]), .active(active), .window(window),
        .cnt(cnt), .rst_req(rst_req), .hit_mid(hit_mid)
    );

    wwd_regs #(.CNT_W(CNT_W), .TB_W(TB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt(cnt), .hit_mid(hit_mid), .active(active),
        .ewe(ewe), .window(window), .tb(tb), .flag(flag),
        .ctrl_load(ctrl_load), .bus_rdata(bus_rdata)
    );

    // The interrupt is the sticky flag itself.
    always_comb irq_early = flag;

    assert_req_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> active);
endmodule

// File: tb/wwd_window_watchdog_test.sv
// Self-checking bench with a cycle-accurate arithmetic model of the watchdog.
module wwd_window_watchdog_test;
    localparam int BASE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        irq_early;

    always #10 clk = ~clk;

    wwd_window_watchdog #(.BASE_LOG2(BASE), .CNT_W(7), .TB_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .irq_early(irq_early)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pulses = 0;
    bit live = 0;
    bit done = 0;

    // Reference model state.
    logic [6:0] m_cnt, m_win;
    logic [2:0] m_tb;
    logic       m_act, m_ewe, m_flag, m_rst;
    int         m_pc, m_per;
    bit         m_tick, m_wctl, m_early;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update on each rising edge from the inputs held across it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 7'h7F; m_win = 7'h7F; m_tb = 3'd0;
            m_act = 1'b0; m_ewe = 1'b0; m_flag = 1'b0; m_rst = 1'b0; m_pc = 0;
        end else begin
            m_per  = 1 << (BASE + int'(m_tb));
            m_tick = (m_pc % m_per) == m_per - 1;
            m_pc   = m_pc + 1;
            m_wctl = bus_wr && bus_addr == 2'd0;
            m_early = m_act && m_cnt > m_win;
            m_rst  = m_act && ((m_wctl && m_cnt > m_win) || (!m_wctl && m_tick && m_cnt == 7'h40));
            if (!m_wctl && m_tick && m_cnt == 7'h41 && m_ewe) m_flag = 1'b1;
            else if (bus_wr && bus_addr == 2'd2 && !bus_wdata[0]) m_flag = 1'b0;
            if (m_wctl) begin
                if (!m_early) m_cnt = bus_wdata[6:0];
                m_act = m_act | bus_wdata[7];
            end else if (m_tick) begin
                m_cnt = m_cnt - 7'd1;
            end
            if (bus_wr && bus_addr == 2'd1) begin
                m_win = bus_wdata[6:0];
                m_tb  = bus_wdata[13:11];
                m_ewe = m_ewe | bus_wdata[9];
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk(rst_req == m_rst, "R3 rst_req cycle", {31'd0, rst_req}, {31'd0, m_rst});
            chk(irq_early == m_flag, "R6 irq_early", {31'd0, irq_early}, {31'd0, m_flag});
            if (rst_req) pulses++;
            if (bus_addr == 2'd0) begin
                chk(bus_rdata[6:0] == m_cnt, "R1 counter value", {25'd0, bus_rdata[6:0]}, {25'd0, m_cnt});
                chk(bus_rdata[7] == m_act, "R4 arm bit", {31'd0, bus_rdata[7]}, {31'd0, m_act});
            end
        end
    end

    // Watchdog on the run length.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        bus_addr = a;
        #5 v = bus_rdata;
        @(posedge clk); #2;
        bus_addr = 2'd0;
    endtask

    task automatic do_reset();
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    logic [31:0] v;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        live = 1;
        #3;
        chk(rst_req == 1'b0 && irq_early == 1'b0, "R2 outputs after reset", {30'd0, rst_req, irq_early}, 32'd0);
        rd(2'd0, v); chk(v[7:0] == 8'h7F, "R2 control reset", v, 32'h7F);
        rd(2'd1, v); chk(v == 32'h7F, "R2 config reset", v, 32'h7F);
        rd(2'd2, v); chk(v == 32'h0, "R2 status reset", v, 32'h0);
        rd(2'd3, v); chk(v == 32'h0, "R8 unused address", v, 32'h0);

        // R1 and R3: every timebase while unarmed; no reset request may appear.
        pulses = 0;
        for (int t = 0; t < 8; t++) begin
            wr(2'd1, (t << 11) | 32'h7F);
            repeat (1500) @(posedge clk);
        end
        chk(pulses == 0, "R3 no request while unarmed", pulses, 0);

        // R3 and R6: arm at timebase 0 with early warning; one pulse at 0x40 -> 0x3F.
        wr(2'd1, 32'h27F);
        wr(2'd0, 32'hFF);
        pulses = 0;
        repeat (400) @(posedge clk);
        #3;
        chk(pulses == 1, "R3 single request when armed", pulses, 1);
        chk(irq_early == 1'b1, "R6 early warning raised", {31'd0, irq_early}, 32'd1);

        // R4: writing 0 to the arm bit does not disarm.
        wr(2'd0, 32'h00);
        rd(2'd0, v); chk(v[7] == 1'b1, "R4 arm stays set", {31'd0, v[7]}, 32'd1);
        // R6: writing 0 to the enable does not clear it.
        wr(2'd1, 32'h7F);
        rd(2'd1, v); chk(v == 32'h27F, "R6 enable stays set", v, 32'h27F);
        // R8: reserved bits ignore writes.
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk(v == 32'h3A7F, "R8 config reserved bits", v, 32'h3A7F);
        wr(2'd1, 32'h27F);

        // R7: status write 1 keeps the flag, write 0 clears it.
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk(v == 32'h1, "R7 write one keeps flag", v, 32'h1);
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk(v == 32'h0, "R7 write zero clears flag", v, 32'h0);

        // R5: refresh above window faults, inside window reloads.
        wr(2'd0, 32'h7F);
        wr(2'd1, 32'h250);
        wr(2'd0, 32'h48);
        chk(rst_req == 1'b1, "R5 early refresh faults", {31'd0, rst_req}, 32'd1);
        #8;
        chk(bus_rdata[6:0] != 7'h48, "R5 early refresh not loaded", {25'd0, bus_rdata[6:0]}, 32'h48);
        wr(2'd1, 32'h27F);
        wr(2'd0, 32'h48);
        chk(rst_req == 1'b0, "R5 refresh inside window", {31'd0, rst_req}, 32'd0);
        wr(2'd1, 32'h250);
        wr(2'd0, 32'h7F);
        chk(rst_req == 1'b0, "R5 refresh at window edge", {31'd0, rst_req}, 32'd0);
        wr(2'd0, 32'h60);
        chk(rst_req == 1'b1, "R5 refresh above window", {31'd0, rst_req}, 32'd1);

        // R5 and R2: unarmed writes always load.
        do_reset();
        #3;
        chk(irq_early == 1'b0, "R2 flag cleared by reset", {31'd0, irq_early}, 32'd0);
        wr(2'd1, 32'h210);
        wr(2'd0, 32'h20);
        chk(rst_req == 1'b0, "R5 unarmed load no fault", {31'd0, rst_req}, 32'd0);
        rd(2'd0, v); chk(v[6:0] == m_cnt && v[7] == 1'b0, "R5 unarmed load value", v, {25'd0, m_cnt});

        repeat (600) @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule